// File: doc/BRIEF.md
# Circular Buffer Pointer Update Unit

This block computes the post-update value of an address pointer for circular buffers. A request carries the current pointer, the index of the pointer register it belongs to, a step selection (increment, decrement, signed offset, or no move), the access size and a modifier word that holds the buffer length minus one. One clock later the unit presents the updated pointer. When modulo arithmetic is in force, the result is folded back into the buffer. A result that runs past the top is reduced by the buffer length, and one that falls under the base is raised by it.

The buffer base is not stored anywhere. It is recovered from the pointer itself by clearing the k low bits, where 2^k is the smallest power of two at least as large as the buffer length. The length itself may be any value from 2 to 16384 and does not have to be a power of two. Only the two lowest-numbered pointer registers may use modulo arithmetic. All other registers, and any request whose modifier is all ones, update linearly with wrap at 2^24.

Top module: `modptr_update`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `next_ptr` is 0 until the first request.
- R2: A request with `in_valid` high yields `out_valid` high exactly one clock later, with `next_ptr` updated in that same cycle; `out_valid` is low one clock after a cycle without a request.
- R3: In a cycle without a request, `next_ptr` keeps its previous value.
- R4: For `ptr_idx` of 2 or more (3-bit index), the result is (`cur_ptr` + step) modulo 2^24, whatever the modifier.
- R5: For `ptr_idx` 0 or 1 with `modifier` = 0xFFFF, the result is linear as in R4, including the carry past 0xFFFFFF to 0.
- R6: `step_mode` encodes 0 = +unit, 1 = −unit, 2 = add `step_ofs` as a signed 24-bit value, 3 = no move. The unit is 2 when `acc_size` = 2 (long), and 1 for `acc_size` 0 (byte), 1 (word) and 3.
- R7: In modulo mode the buffer length is M = `modifier` + 1, the base is `cur_ptr` with its k low bits cleared (2^k the least power of two ≥ M), and the top is base + M − 1. A pointer inside the buffer moved by a step of magnitude at most M ends inside the buffer.
- R8: In modulo mode a raw sum above the top, whether it lands just past it or beyond, is reduced by M.
- R9: In modulo mode a raw sum below the base, whether it lands just under it or beyond, is increased by M.
- R10: Buffer lengths that are exact powers of two (`modifier` = 2^k − 1), including the largest length of 16384, wrap across the whole aligned 2^k block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| ptr_idx | input | 3 | Pointer register index; 0 and 1 may use modulo mode |
| cur_ptr | input | 24 | Pointer value before the update |
| step_mode | input | 2 | Step selection (see R6) |
| acc_size | input | 2 | Access size: 0 byte, 1 word, 2 long |
| step_ofs | input | 24 | Signed offset used when `step_mode` = 2 |
| modifier | input | 16 | Buffer length minus one; 0xFFFF selects linear update |
| out_valid | output | 1 | Result strobe, one clock after the request |
| next_ptr | output | 24 | Updated pointer |

## Verification
A new request is accepted in the same cycle that the result of the previous one is presented. The bench therefore streams requests on every clock and mixes wrapping, non-wrapping and linear cases back to back. Each result is compared one cycle after its request against a model that finds the power-of-two block by search, so a result that leaks from its neighbour shows up as a mismatch. Directed cases cover exact and overshooting wraps at both ends, the long-access unit and the largest buffer. Random requests keep the step magnitude within the buffer length.

// File: rtl/modptr_pkg.sv
`timescale 1ns/1ps
package modptr_pkg;

    typedef enum logic [1:0] {
        STEP_INC  = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_ADD  = 2'd2,
        STEP_HOLD = 2'd3
    } step_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/modptr_step_gen.sv
`timescale 1ns/1ps
module modptr_step_gen #(
    parameter int AW = 24
) (
    input  logic [1:0]        step_mode,
    input  logic [1:0]        acc_size,
    input  logic [AW-1:0]     step_ofs,
    output logic signed [AW:0] step
);
    import modptr_pkg::*;

    logic signed [AW:0] unit;

    always_comb begin
        unit = (acc_size_e'(acc_size) == SZ_LONG) ? (AW+1)'(2) : (AW+1)'(1);
        case (step_mode_e'(step_mode))
            STEP_INC: step = unit;
            STEP_DEC: step = -unit;
            STEP_ADD: step = $signed({step_ofs[AW-1], step_ofs});
            default:  step = '0;
        endcase
    end
endmodule

// File: rtl/modptr_bounds.sv
`timescale 1ns/1ps
module modptr_bounds #(
    parameter int AW = 24,
    parameter int MW = 16
) (
    input  logic [AW-1:0] cur_ptr,
    input  logic [MW-1:0] modifier,
    output logic [AW-1:0] base,
    output logic [AW:0]   upper,
    output logic [MW:0]   buf_len
);
    logic [AW-1:0] low_mask;

    // every bit at or below the highest set modifier bit belongs to the block
    for (genvar i = 0; i < AW; i++) begin : g_mask
        if (i < MW) begin : g_live
            assign low_mask[i] = |modifier[MW-1:i];
        end else begin : g_dead
            assign low_mask[i] = 1'b0;
        end
    end

    always_comb begin
        base    = cur_ptr & ~low_mask;
        upper   = {1'b0, base} + (AW+1)'(modifier);
        buf_len = {1'b0, modifier} + (MW+1)'(1);
    end
endmodule

// File: rtl/modptr_fold.sv
`timescale 1ns/1ps
module modptr_fold #(
    parameter int AW = 24,
    parameter int MW = 16
) (
    input  logic [AW-1:0]      cur_ptr,
    input  logic signed [AW:0] step,
    input  logic [AW-1:0]      base,
    input  logic [AW:0]        upper,
    input  logic [MW:0]        buf_len,
    input  logic               mod_en,
    output logic [AW-1:0]      result
);
    localparam int SW = AW + 2;

    logic signed [SW-1:0] raw_sum;
    logic signed [SW-1:0] base_s;
    logic signed [SW-1:0] upper_s;
    logic signed [SW-1:0] len_s;
    logic signed [SW-1:0] folded;

    always_comb begin
        raw_sum = $signed({2'b00, cur_ptr}) + $signed({step[AW], step});
        base_s  = $signed({2'b00, base});
        upper_s = $signed({1'b0, upper});
        len_s   = $signed({{(SW-MW-1){1'b0}}, buf_len});
        folded  = raw_sum;
        if (mod_en) begin
            if (raw_sum > upper_s) begin
                folded = raw_sum - len_s;
            end else if (raw_sum < base_s) begin
                folded = raw_sum + len_s;
            end
        end
        result = folded[AW-1:0];
    end
endmodule

// File: rtl/modptr_update.sv
`timescale 1ns/1ps
module modptr_update #(
    parameter int AW       = 24,
    parameter int MW       = 16,
    parameter int IDXW     = 3,
    parameter int MOD_PTRS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IDXW-1:0] ptr_idx,
    input  logic [AW-1:0]   cur_ptr,
    input  logic [1:0]      step_mode,
    input  logic [1:0]      acc_size,
    input  logic [AW-1:0]   step_ofs,
    input  logic [MW-1:0]   modifier,
    output logic            out_valid,
    output logic [AW-1:0]   next_ptr
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] ptr;
    } upd_state_t;

    upd_state_t st_d, st_q;

    logic signed [AW:0] step;
    logic [AW-1:0]      base;
    logic [AW:0]        upper;
    logic [MW:0]        buf_len;
    logic               mod_en;
    logic [AW-1:0]      nxt;

    assign mod_en = (ptr_idx < IDXW'(MOD_PTRS)) && (modifier != {MW{1'b1}});

    modptr_step_gen #(.AW(AW)) step_i (
        .step_mode (step_mode),
        .acc_size  (acc_size),
        .step_ofs  (step_ofs),
        .step      (step)
    );

    modptr_bounds #(.AW(AW), .MW(MW)) bounds_i (
        .cur_ptr  (cur_ptr),
        .modifier (modifier),
        .base     (base),
        .upper    (upper),
        .buf_len  (buf_len)
    );

    modptr_fold #(.AW(AW), .MW(MW)) fold_i (
        .cur_ptr (cur_ptr),
        .step    (step),
        .base    (base),
        .upper   (upper),
        .buf_len (buf_len),
        .mod_en  (mod_en),
        .result  (nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ptr = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign next_ptr  = st_q.ptr;

    // checker-side terms for the range property
    logic [AW:0] chk_step_mag;
    logic        chk_in_buf;
    logic        chk_step_ok;
    always_comb begin
        chk_step_mag = step[AW] ? (AW+1)'(-step) : (AW+1)'(step);
        chk_in_buf   = ({1'b0, cur_ptr} <= upper);
        chk_step_ok  = (chk_step_mag <= (AW+1)'(buf_len));
    end

    assert_result_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(next_ptr));

    assert_linear_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (ptr_idx >= IDXW'(MOD_PTRS)))
        |=> next_ptr == AW'($past(cur_ptr) + $past(step[AW-1:0])));

    assert_stays_in_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mod_en && chk_in_buf && chk_step_ok)
        |=> ((next_ptr >= $past(base)) && ({1'b0, next_ptr} <= $past(upper))));

endmodule

// File: tb/modptr_update_tb_top.sv
`timescale 1ns/1ps
module modptr_update_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  ptr_idx = '0;
    logic [23:0] cur_ptr = '0;
    logic [1:0]  step_mode = '0;
    logic [1:0]  acc_size = '0;
    logic [23:0] step_ofs = '0;
    logic [15:0] modifier = '0;
    logic        out_valid;
    logic [23:0] next_ptr;

    int checks = 0;
    int errors = 0;

    logic        pend = 1'b0;
    logic [23:0] pend_exp = '0;
    string       pend_tag = "";

    always #4 clk = ~clk;

    modptr_update dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ptr_idx   (ptr_idx),
        .cur_ptr   (cur_ptr),
        .step_mode (step_mode),
        .acc_size  (acc_size),
        .step_ofs  (step_ofs),
        .modifier  (modifier),
        .out_valid (out_valid),
        .next_ptr  (next_ptr)
    );

    task automatic chk(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    function automatic longint model(input int idx, input int mode, input int sz,
                                     input longint ptr, input longint ofs24, input int md);
        longint st, s, m, p2, b;
        longint unit;
        unit = (sz == 2) ? 2 : 1;
        case (mode)
            0: st = unit;
            1: st = -unit;
            2: st = (ofs24 >= 64'h800000) ? ofs24 - 64'h1000000 : ofs24;
            default: st = 0;
        endcase
        s = ptr + st;
        if (idx >= 2 || md == 16'hFFFF) return s & 64'hFFFFFF;
        m = md + 1;
        p2 = 1;
        while (p2 < m) p2 = p2 * 2;
        b = ptr - (ptr % p2);
        if (s > b + m - 1) s = s - m;
        else if (s < b) s = s + m;
        return s & 64'hFFFFFF;
    endfunction

    // check any pending result, then drive a new request
    task automatic issue(input int idx, input int mode, input int sz, input longint ptr,
                         input longint ofs, input int md, input longint exp, input string tag);
        @(negedge clk);
        if (pend) begin
            chk({pend_tag, " R2 strobe"}, out_valid, 1);
            chk(pend_tag, next_ptr, pend_exp);
        end
        in_valid  = 1'b1;
        ptr_idx   = 3'(idx);
        step_mode = 2'(mode);
        acc_size  = 2'(sz);
        cur_ptr   = 24'(ptr);
        step_ofs  = 24'(ofs);
        modifier  = 16'(md);
        pend      = 1'b1;
        pend_exp  = 24'(exp);
        pend_tag  = tag;
    endtask

    task automatic flush();
        @(negedge clk);
        if (pend) begin
            chk({pend_tag, " R2 strobe"}, out_valid, 1);
            chk(pend_tag, next_ptr, pend_exp);
        end
        in_valid = 1'b0;
        cur_ptr  = 24'h5A5A5A;
        pend     = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] held;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 ptr in reset", next_ptr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", out_valid, 0);
        chk("R1 ptr after reset", next_ptr, 0);

        // directed corners, streamed back to back
        issue(0, 0, 1, 24'h000108, 0, 16'h0008, 24'h000100, "R8 inc at top");
        issue(0, 1, 1, 24'h000100, 0, 16'h0008, 24'h000108, "R9 dec at base");
        issue(1, 2, 1, 24'h000106, 5, 16'h0008, 24'h000102, "R8 overshoot top");
        issue(1, 2, 1, 24'h000101, 24'hFFFFFC, 16'h0008, 24'h000106, "R9 overshoot base");
        issue(0, 0, 2, 24'h000107, 0, 16'h0008, 24'h000100, "R6 long unit wrap");
        issue(0, 1, 0, 24'h000104, 0, 16'h0008, 24'h000103, "R6 byte dec inside");
        issue(0, 3, 1, 24'h000105, 0, 16'h0008, 24'h000105, "R6 no move");
        issue(1, 0, 1, 24'h00012F, 0, 16'h000F, 24'h000120, "R10 pow2 top");
        issue(1, 1, 1, 24'h000120, 0, 16'h000F, 24'h00012F, "R10 pow2 base");
        issue(0, 0, 1, 24'h007FFF, 0, 16'h3FFF, 24'h004000, "R10 largest buffer");
        issue(0, 2, 1, 24'h000103, 3, 16'h0008, 24'h000106, "R7 inside no wrap");
        issue(0, 0, 1, 24'h000108, 0, 16'hFFFF, 24'h000109, "R5 linear modifier");
        issue(1, 0, 1, 24'hFFFFFF, 0, 16'hFFFF, 24'h000000, "R5 linear carry");
        issue(3, 0, 1, 24'h000108, 0, 16'h0008, 24'h000109, "R4 other pointer");
        issue(7, 1, 1, 24'h000000, 0, 16'h0008, 24'hFFFFFF, "R4 linear borrow");
        flush();

        held = next_ptr;
        @(negedge clk);
        chk("R2 idle strobe", out_valid, 0);
        chk("R3 hold ptr", next_ptr, held);
        @(negedge clk);
        chk("R3 hold ptr again", next_ptr, held);

        // constrained random, streamed
        for (int n = 0; n < 400; n++) begin
            int idx, mode, sz, md;
            longint m, p2, b, ptr, ofs, mag;
            idx  = $urandom_range(0, 7);
            mode = $urandom_range(0, 3);
            sz   = $urandom_range(0, 3);
            if ($urandom_range(0, 9) == 0) md = 16'hFFFF;
            else if ($urandom_range(0, 1) == 0) md = $urandom_range(1, 40);
            else md = $urandom_range(1, 16'h3FFF);
            m = md + 1;
            p2 = 1;
            while (p2 < m) p2 = p2 * 2;
            if (md == 16'hFFFF || idx >= 2) begin
                ptr = longint'($urandom()) & 64'hFFFFFF;
                ofs = longint'($urandom()) & 64'hFFFFFF;
            end else begin
                b   = (longint'($urandom()) & 64'hFFFFFF) & ~(p2 - 1);
                ptr = b + longint'($urandom_range(0, int'(m - 1)));
                mag = longint'($urandom_range(0, int'(m)));
                ofs = ($urandom_range(0, 1) == 1) ? mag : ((64'h1000000 - mag) & 64'hFFFFFF);
            end
            issue(idx, mode, sz, ptr, ofs, md, model(idx, mode, sz, ptr, ofs, md),
                  (idx >= 2) ? "R4 random" : ((md == 16'hFFFF) ? "R5 random" : "R7 random"));
        end
        flush();
        @(negedge clk);
        chk("R2 final idle", out_valid, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule